// File: doc/BRIEF.md
# Serial NOR Flash Target Model

This block is a synthesizable model of a small serial NOR flash. It sits on an SPI mode-0 bus: the host pulls the active-low select low, shifts a one-byte command MSB first on the rising serial clock, and reads replies on the same edges. The target samples the serial lines with its own system clock, so the serial clock must run several times slower than `clk`.

The target holds a byte array that starts fully erased, a page buffer, and a two-bit status byte (bit 0 busy, bit 1 write-enable latch). Modify commands take effect only when select rises at a byte boundary. Each one starts an internal cycle whose length comes from parameters. During that cycle the target walks the affected bytes one per clock. A sleep command locks out all modify commands until a wake command arrives.

Top module: `spi_nor_target`

## Requirements
- R1: After reset the status byte is 00h and every array byte reads FFh.
- R2: Command 06h, when accepted, sets the write-enable latch (status bit 1) at select rise. Command 05h returns the current status byte in every following byte of the frame. Status bit 0 is the busy flag.
- R3: Command 03h followed by three address bytes (MSB first, taken modulo the array size) returns bytes from consecutive addresses, wrapping from the last array byte to address 0.
- R4: Command 02h with three address bytes and data bytes merges each data byte into the stored byte by bitwise AND. Without a set write-enable latch the command is discarded and the status byte does not change.
- R5: Program data fills consecutive columns of one 256-byte page, and the column wraps to the start of that page. Bytes outside the page are unchanged.
- R6: Command D8h with an address sets the whole 512-byte sector holding that address to FFh. Command C7h sets the whole array to FFh. Both are discarded unless the write-enable latch is set.
- R7: From the select rise of an accepted program or erase until its internal cycle completes, status bit 0 reads 1. When the cycle ends, both status bits read 0.
- R8: While the busy flag is set, only 05h acts. A read returns 00h data, and every other command is ignored.
- R9: A modify command whose frame ends with select rising partway through a byte is discarded, and the write-enable latch keeps its value.
- R10: After command B9h, commands 06h, 02h, D8h and C7h are ignored until command ABh is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low (mode 0) |
| mosi | input | 1 | Serial data from host, sampled on rising sclk |
| miso | output | 1 | Serial data to host, changes after falling sclk |

## Verification
The assertions assume the serial lines are well behaved for an oversampling receiver. Each sclk level and each cs_n level must last longer than the synchronizer depth plus one clock. sclk must be low whenever cs_n changes. The bench holds each sclk phase for five system clocks and leaves a twenty-clock gap after every frame. It changes mosi only while sclk is low. With these rules, busy-flag and latch transitions seen by the assertions are caused only by whole, decoded frames.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_BERASE = 8'hC7;
  localparam logic [7:0] OP_SLEEP  = 8'hB9;
  localparam logic [7:0] OP_WAKE   = 8'hAB;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_PROG, PH_READ, PH_STAT, PH_SKIP
  } phase_t;

  typedef enum logic {SW_PROG, SW_FILL} sweep_t;

  // Internal cycle length: never shorter than the bytes it must walk.
  function automatic int busy_len(int req, int span);
    return (req > span) ? req : span;
  endfunction

endpackage

// File: rtl/spi_nor_link.sv
module spi_nor_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] tx_next,
  output logic       miso,
  output logic       frame_start,
  output logic       frame_end,
  output logic       frame_aligned,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] cs_sync, ck_sync, di_sync;
  logic         cs_d, ck_d;
  logic         cs_lvl, ck_lvl, di_lvl, ck_rise, ck_fall;
  logic [2:0]   bit_cnt;
  logic [6:0]   shreg;
  logic [7:0]   tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync <= '1;
      ck_sync <= '0;
      di_sync <= '0;
      cs_d    <= 1'b1;
      ck_d    <= 1'b0;
    end else begin
      cs_sync <= {cs_sync[MSB-1:0], cs_n};
      ck_sync <= {ck_sync[MSB-1:0], sclk};
      di_sync <= {di_sync[MSB-1:0], mosi};
      cs_d    <= cs_sync[MSB];
      ck_d    <= ck_sync[MSB];
    end
  end

  assign cs_lvl  = cs_sync[MSB];
  assign ck_lvl  = ck_sync[MSB];
  assign di_lvl  = di_sync[MSB];
  assign ck_rise = ck_lvl & ~ck_d & ~cs_lvl;
  assign ck_fall = ~ck_lvl & ck_d & ~cs_lvl;

  assign frame_start   = ~cs_lvl & cs_d;
  assign frame_end     = cs_lvl & ~cs_d;
  assign frame_aligned = (bit_cnt == 3'd0);
  assign byte_done     = ck_rise && (bit_cnt == 3'd7);
  assign rx_byte       = {shreg, di_lvl};
  assign miso          = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      tx_sh   <= '0;
    end else if (cs_lvl) begin
      bit_cnt <= '0;
      tx_sh   <= '0;
    end else begin
      if (ck_rise) begin
        shreg   <= {shreg[5:0], di_lvl};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (ck_fall) begin
        tx_sh <= (bit_cnt == 3'd0) ? tx_next : {tx_sh[6:0], 1'b0};
      end
    end
  end

  // R9: a completed byte never lands outside a selected frame
  a_r9_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !cs_n || $past(!cs_n));

endmodule

// File: rtl/spi_nor_busy.sv
module spi_nor_busy #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             wip,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign wip  = (cnt != '0);
  assign done = (cnt == CNT_W'(1)) && !load;

  // R7: the busy flag only drops through the completion pulse
  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> $past(done));

endmodule

// File: rtl/spi_nor_array.sv
module spi_nor_array import spi_nor_pkg::*; #(
  parameter int MEM_BYTES  = 1024,
  parameter int PAGE_BYTES = 256,
  parameter int AW         = $clog2(MEM_BYTES),
  parameter int CW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          pb_clear,
  input  logic          pb_we,
  input  logic [CW-1:0] pb_col,
  input  logic [7:0]    pb_data,
  input  logic          sw_start,
  input  sweep_t        sw_kind,
  input  logic [AW-1:0] sw_base,
  input  logic [AW:0]   sw_len,
  output logic          sw_active
);
  logic [7:0]    mem  [MEM_BYTES];
  logic [7:0]    pbuf [PAGE_BYTES];
  logic [AW-1:0] ptr;
  logic [AW:0]   left;
  sweep_t        kind;
  logic [7:0]    wr_val;

  assign rd_data   = mem[rd_addr];
  assign sw_active = (left != '0);
  assign wr_val    = (kind == SW_PROG) ? (mem[ptr] & pbuf[ptr[CW-1:0]]) : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      left <= '0;
      kind <= SW_FILL;
    end else if (sw_start) begin
      ptr  <= sw_base;
      left <= sw_len;
      kind <= sw_kind;
    end else if (sw_active) begin
      ptr  <= ptr + 1'b1;
      left <= left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (sw_active) begin
      mem[ptr] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else if (pb_clear) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else if (pb_we) begin
      pbuf[pb_col] <= pb_data;
    end
  end

  // R6: a walk never runs past the end of the array
  a_r6_sweep_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    sw_active |-> ({1'b0, ptr} + left) <= (AW+1)'(MEM_BYTES));

  // R8: the page buffer is never refilled while a walk uses it
  a_r8_buffer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sw_active && kind == SW_PROG |-> !pb_clear && !pb_we);

endmodule

// File: rtl/spi_nor_target.sv
module spi_nor_target import spi_nor_pkg::*; #(
  parameter int MEM_BYTES     = 1024,
  parameter int PAGE_BYTES    = 256,
  parameter int SECTOR_BYTES  = 512,
  parameter int PROG_CYCLES   = 300,
  parameter int SERASE_CYCLES = 600,
  parameter int BERASE_CYCLES = 1500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso
);
  localparam int AW      = $clog2(MEM_BYTES);
  localparam int CW      = $clog2(PAGE_BYTES);
  localparam int T_PROG  = busy_len(PROG_CYCLES, PAGE_BYTES);
  localparam int T_SE    = busy_len(SERASE_CYCLES, SECTOR_BYTES);
  localparam int T_BE    = busy_len(BERASE_CYCLES, MEM_BYTES);
  localparam int T_MAX   = busy_len(busy_len(T_PROG, T_SE), T_BE);
  localparam int CNT_W   = $clog2(T_MAX + 1);

  function automatic logic [AW-1:0] align_down(logic [AW-1:0] a, int span);
    logic [AW-1:0] m;
    m = AW'(span - 1);
    return a & ~m;
  endfunction

  // link side
  logic       frame_start, frame_end, frame_aligned, byte_done;
  logic [7:0] rx_byte;

  // controller state
  phase_t        phase;
  logic [7:0]    cmd, tx_next, status;
  logic [AW-1:0] addr, first_addr, rd_ptr, rd_addr, sw_base;
  logic [1:0]    addr_cnt;
  logic [CW-1:0] col;
  logic          blocked, wel, dpd;

  // named events
  logic             cmd_seen, may_modify;
  logic             do_wren, do_prog, do_se, do_be, do_sleep, do_wake;
  logic             sw_start, sw_active, wip, busy_done;
  logic             pb_clear, pb_we;
  logic [7:0]       rd_data;
  logic [AW:0]      sw_len;
  logic [CNT_W-1:0] busy_val;
  sweep_t           sw_kind;

  spi_nor_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .tx_next(tx_next), .miso(miso), .frame_start(frame_start),
    .frame_end(frame_end), .frame_aligned(frame_aligned),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  assign status     = {6'b0, wel, wip};
  assign first_addr = AW'({addr, rx_byte});
  assign rd_addr    = (phase == PH_ADDR) ? first_addr : rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      cmd      <= '0;
      tx_next  <= '0;
      addr     <= '0;
      addr_cnt <= '0;
      col      <= '0;
      rd_ptr   <= '0;
      blocked  <= 1'b0;
    end else if (frame_start || frame_end) begin
      phase    <= PH_CMD;
      tx_next  <= '0;
      addr_cnt <= '0;
      blocked  <= 1'b0;
    end else if (byte_done) begin
      unique case (phase)
        PH_CMD: begin
          cmd <= rx_byte;
          if (rx_byte == OP_RDSR) begin
            phase   <= PH_STAT;
            tx_next <= status;
          end else if (wip) begin
            phase   <= PH_SKIP;
            blocked <= 1'b1;
          end else if (rx_byte == OP_READ || rx_byte == OP_PROG ||
                       rx_byte == OP_SERASE) begin
            phase <= PH_ADDR;
          end else begin
            phase <= PH_SKIP;
          end
        end
        PH_ADDR: begin
          addr     <= first_addr;
          addr_cnt <= addr_cnt + 2'd1;
          if (addr_cnt == 2'd2) begin
            if (cmd == OP_READ) begin
              phase   <= PH_READ;
              tx_next <= rd_data;
              rd_ptr  <= first_addr + 1'b1;
            end else if (cmd == OP_PROG) begin
              phase <= PH_PROG;
              col   <= first_addr[CW-1:0];
            end else begin
              phase <= PH_SKIP;
            end
          end
        end
        PH_PROG: col <= col + 1'b1;
        PH_READ: begin
          tx_next <= rd_data;
          rd_ptr  <= rd_ptr + 1'b1;
        end
        PH_STAT: tx_next <= status;
        default: ;
      endcase
    end
  end

  assign pb_clear = byte_done && phase == PH_ADDR && addr_cnt == 2'd2 && cmd == OP_PROG;
  assign pb_we    = byte_done && phase == PH_PROG;

  // frame-end decode
  assign cmd_seen   = frame_end && frame_aligned && phase != PH_CMD && !blocked && !wip;
  assign may_modify = cmd_seen && !dpd;
  assign do_wren    = may_modify && cmd == OP_WREN;
  assign do_prog    = may_modify && wel && cmd == OP_PROG && phase == PH_PROG;
  assign do_se      = may_modify && wel && cmd == OP_SERASE && phase == PH_SKIP;
  assign do_be      = may_modify && wel && cmd == OP_BERASE;
  assign do_sleep   = cmd_seen && cmd == OP_SLEEP;
  assign do_wake    = cmd_seen && cmd == OP_WAKE;

  assign sw_start = do_prog || do_se || do_be;
  assign sw_kind  = do_prog ? SW_PROG : SW_FILL;

  always_comb begin
    if (do_prog) begin
      sw_base  = align_down(addr, PAGE_BYTES);
      sw_len   = (AW+1)'(PAGE_BYTES);
      busy_val = CNT_W'(T_PROG);
    end else if (do_se) begin
      sw_base  = align_down(addr, SECTOR_BYTES);
      sw_len   = (AW+1)'(SECTOR_BYTES);
      busy_val = CNT_W'(T_SE);
    end else begin
      sw_base  = '0;
      sw_len   = (AW+1)'(MEM_BYTES);
      busy_val = CNT_W'(T_BE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
      dpd <= 1'b0;
    end else begin
      if (busy_done)    wel <= 1'b0;
      else if (do_wren) wel <= 1'b1;
      if (do_sleep)     dpd <= 1'b1;
      else if (do_wake) dpd <= 1'b0;
    end
  end

  spi_nor_busy #(.CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(sw_start), .load_val(busy_val),
    .wip(wip), .done(busy_done)
  );

  spi_nor_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
                  .AW(AW), .CW(CW)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .pb_clear(pb_clear), .pb_we(pb_we), .pb_col(col), .pb_data(rx_byte),
    .sw_start(sw_start), .sw_kind(sw_kind), .sw_base(sw_base),
    .sw_len(sw_len), .sw_active(sw_active)
  );

  // R4 / R6: modify cycles start only with the latch set
  a_r4_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |-> wel);

  // R2: the latch only rises through an accepted 06h frame
  a_r2_latch_from_wren: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(do_wren));

  // R7: busy begins only with a walk start and ends with the latch cleared
  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(sw_start));
  a_r7_latch_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  // R7: the array walk finishes inside the busy window
  a_r7_walk_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sw_active |-> wip);

  // R8: nothing new starts while busy
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !sw_start && !do_wren);

  // R10: sleeping blocks modify commands
  a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dpd |-> !sw_start && !do_wren);

endmodule

// File: tb/tb_spi_nor_target.sv
module tb_spi_nor_target;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  logic [7:0] obuf [16];
  logic [7:0] ibuf [16];

  always #5 clk = ~clk;

  spi_nor_target dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // program / read vectors: [31:16] address, [15:8] data, [7:0] expected
  localparam logic [31:0] VEC [6] = '{
    {16'h0010, 8'hA5, 8'hA5},
    {16'h0010, 8'h0F, 8'h05},
    {16'h01FF, 8'h00, 8'h00},
    {16'h0300, 8'h7E, 8'h7E},
    {16'h0300, 8'hFF, 8'h7E},
    {16'h0201, 8'hC3, 8'hC3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic frame(input int nbytes, input int tail_bits);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = obuf[b][i];
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        ibuf[b][i] = miso;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
    end
    for (int i = 0; i < tail_bits; i++) begin
      mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    obuf[0] = op;
    frame(1, 0);
  endtask

  task automatic get_status(output logic [7:0] st);
    obuf[0] = 8'h05;
    frame(2, 0);
    st = ibuf[1];
  endtask

  task automatic addr_cmd(input logic [7:0] op, input logic [15:0] a);
    obuf[0] = op;
    obuf[1] = 8'h00;
    obuf[2] = a[15:8];
    obuf[3] = a[7:0];
  endtask

  task automatic read_n(input logic [15:0] a, input int n);
    addr_cmd(8'h03, a);
    for (int k = 0; k < n; k++) obuf[4 + k] = 8'h00;
    frame(4 + n, 0);
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int k = 0; k < 100; k++) begin
      get_status(st);
      if (st[0] == 1'b0) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    get_status(st);
    chk("R1 status", st, 8'h00);
    read_n(16'h0000, 1);
    chk("R1 byte 0", ibuf[4], 8'hFF);
    read_n(16'h03FF, 1);
    chk("R1 last byte", ibuf[4], 8'hFF);

    // R4 program without latch is discarded
    addr_cmd(8'h02, 16'h0050); obuf[4] = 8'h00;
    frame(5, 0);
    get_status(st);
    chk("R4 no busy", st, 8'h00);
    read_n(16'h0050, 1);
    chk("R4 discarded", ibuf[4], 8'hFF);

    // R2 latch and repeated status
    op1(8'h06);
    obuf[0] = 8'h05;
    frame(4, 0);
    chk("R2 status b1", ibuf[1], 8'h02);
    chk("R2 status b3", ibuf[3], 8'h02);

    // R9 misaligned frame end
    addr_cmd(8'h02, 16'h0020); obuf[4] = 8'h00;
    frame(5, 3);
    get_status(st);
    chk("R9 latch kept", st, 8'h02);
    read_n(16'h0020, 1);
    chk("R9 discarded", ibuf[4], 8'hFF);

    // R4 vector walk
    foreach (VEC[v]) begin
      op1(8'h06);
      addr_cmd(8'h02, VEC[v][31:16]); obuf[4] = VEC[v][15:8];
      frame(5, 0);
      wait_idle();
      read_n(VEC[v][31:16], 1);
      chk("R4 and-merge", ibuf[4], VEC[v][7:0]);
    end

    // R5 page wrap
    op1(8'h06);
    addr_cmd(8'h02, 16'h00FE);
    obuf[4] = 8'h11; obuf[5] = 8'h22; obuf[6] = 8'h33; obuf[7] = 8'h44;
    frame(8, 0);
    wait_idle();
    get_status(st);
    chk("R7 idle after program", st, 8'h00);
    read_n(16'h00FE, 2);
    chk("R5 col FE", ibuf[4], 8'h11);
    chk("R5 col FF", ibuf[5], 8'h22);
    read_n(16'h0000, 2);
    chk("R5 wrapped col 0", ibuf[4], 8'h33);
    chk("R5 wrapped col 1", ibuf[5], 8'h44);
    read_n(16'h0100, 1);
    chk("R5 next page untouched", ibuf[4], 8'hFF);

    // R3 read wraps at array end
    read_n(16'h03FF, 2);
    chk("R3 array wrap", ibuf[5], 8'h33);

    // R6 sector erase needs latch
    addr_cmd(8'hD8, 16'h0000);
    frame(4, 0);
    read_n(16'h0010, 1);
    chk("R6 erase without latch", ibuf[4], 8'h05);

    // R6 / R7 sector erase
    op1(8'h06);
    addr_cmd(8'hD8, 16'h00AB);
    frame(4, 0);
    get_status(st);
    chk("R7 busy during erase", st, 8'h03);
    wait_idle();
    read_n(16'h0010, 1);
    chk("R6 sector byte", ibuf[4], 8'hFF);
    read_n(16'h01FF, 1);
    chk("R6 sector end", ibuf[4], 8'hFF);
    read_n(16'h0201, 1);
    chk("R6 other sector", ibuf[4], 8'hC3);

    // R8 / R6 bulk erase
    op1(8'h06);
    op1(8'hC7);
    read_n(16'h0201, 1);
    chk("R8 read while busy", ibuf[4], 8'h00);
    get_status(st);
    chk("R7 busy bulk", st, 8'h03);
    wait_idle();
    get_status(st);
    chk("R7 idle after erase", st, 8'h00);
    read_n(16'h0300, 1);
    chk("R6 bulk 300", ibuf[4], 8'hFF);
    read_n(16'h0201, 1);
    chk("R6 bulk 201", ibuf[4], 8'hFF);

    // R10 sleep gating
    op1(8'hB9);
    op1(8'h06);
    get_status(st);
    chk("R10 latch blocked", st, 8'h00);
    op1(8'hAB);
    op1(8'h06);
    get_status(st);
    chk("R10 latch after wake", st, 8'h02);
    addr_cmd(8'h02, 16'h0040); obuf[4] = 8'h00;
    frame(5, 0);
    wait_idle();
    read_n(16'h0040, 1);
    chk("R10 program after wake", ibuf[4], 8'h00);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule